// File: doc/BRIEF.md
# Endpoint DMA Descriptor Progress Tracker

This block follows one transfer descriptor of a USB device endpoint from the moment software loads it until it is finished. A load supplies the buffer length, the buffer start address and whether the endpoint is isochronous. After that the block takes per-byte and end-of-packet events from the endpoint side and an error strobe from the system-bus master. It keeps the running buffer address and the amount transferred. It reports a 3-bit outcome code, a retired flag and a packet-valid flag. It drops the endpoint's DMA enable on fatal outcomes and pulses a request for the next descriptor when the current one is finished.

The length unit depends on the endpoint type. Isochronous endpoints count whole packets. All other endpoints count bytes and can also end early on a short packet, or end late when the buffer fills in the middle of a packet. Once a descriptor is finished, every packet event is ignored until the next load. The reset input is asynchronous and active low, and is expected to be released in step with the clock.

Top module: `ep_dd_tracker`

## Requirements
- R1: A load (`ld_valid`=1) takes priority over every other input. On the next cycle it gives `status`=0 (untouched), `retired`=0, `dma_en`=1, `xfer_cnt`=0, `cur_addr`=`ld_addr` and `next_req`=0. After reset, `status`=0, `retired`=0, `dma_en`=0, `xfer_cnt`=0, `cur_addr`=0, `next_req`=0 and `pkt_valid`=1.
- R2: On a non-isochronous descriptor, `xfer_cnt` counts `byte_ev` strobes. On an isochronous descriptor, it counts `pkt_end` strobes and ignores `byte_ev`.
- R3: Each accepted `pkt_end` adds `pkt_bytes` to `cur_addr`. No other event changes `cur_addr`.
- R4: An accepted `pkt_end` that does not finish the descriptor sets `status`=1 (in progress). Byte strobes alone never leave `status`=0.
- R5: When the count reaches the loaded length on a packet boundary (a non-isochronous last byte together with `pkt_end`, or an isochronous `pkt_end`), the block sets `status`=2 (done), sets `retired`=1, keeps `dma_en`=1, and pulses `next_req` high for exactly one cycle.
- R6: On a non-isochronous descriptor, a `pkt_end` whose `pkt_bytes` is less than `mps` (zero included) and that does not reach the length sets `status`=3 (short), `retired`=1 and `next_req` for one cycle.
- R7: On a non-isochronous descriptor, a byte that reaches the length without `pkt_end` sets `status`=4 (overflow), `retired`=1, `xfer_cnt` equal to the length and `dma_en`=0, with no `next_req`.
- R8: `bus_err` on an active descriptor sets `status`=5 (bus fault) and `dma_en`=0, leaves `retired`=0 and raises no `next_req`. It wins over packet events in the same cycle, and those packet events change neither the address nor the count.
- R9: On an isochronous descriptor, `pkt_valid` equals the inverse of `pkt_err` of the last accepted packet, and is 0 after a load until the first packet. On a non-isochronous descriptor, `pkt_valid` is 1.
- R10: When the descriptor is retired, hit a bus fault or was never loaded, byte, packet and bus-error events leave `cur_addr`, `xfer_cnt`, `status`, `retired` and `dma_en` unchanged until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Load a new descriptor this cycle |
| ld_len | input | LEN_W (12) | Buffer length: packets if isochronous, bytes otherwise |
| ld_addr | input | ADDR_W (32) | Buffer start address |
| ld_iso | input | 1 | Descriptor belongs to an isochronous endpoint |
| mps | input | PKT_W (11) | Configured maximum packet size in bytes |
| byte_ev | input | 1 | One byte moved this cycle |
| pkt_end | input | 1 | A packet finished this cycle (arrives with its last byte, or alone for a zero-length packet) |
| pkt_bytes | input | PKT_W (11) | Byte count of the packet that finished |
| pkt_err | input | 1 | The finished packet was received with errors (isochronous) |
| bus_err | input | 1 | System-bus error reported by the bus master |
| cur_addr | output | ADDR_W (32) | Current buffer address |
| xfer_cnt | output | LEN_W (12) | Amount transferred in the length unit |
| status | output | 3 | Outcome code: 0 untouched, 1 in progress, 2 done, 3 short, 4 overflow, 5 bus fault |
| retired | output | 1 | Descriptor finished |
| pkt_valid | output | 1 | Last packet written was error-free |
| dma_en | output | 1 | Endpoint DMA enable |
| next_req | output | 1 | One-cycle request to fetch the next descriptor |

## Verification
The bench covers several boundary cases:
- A last byte arriving together with `pkt_end`, against the same byte arriving one cycle before it. A design that mixes these up reports overflow on a clean finish, or finishes cleanly when it should have overflowed.
- A zero-length packet, which must count as short. A design that gets this wrong keeps running past the early end.
- A bus error in the same cycle as a packet end. A design with the wrong priority advances the address or retires the descriptor.
- Packet events after a descriptor has finished. A design that fails to ignore them moves the address or count, or raises `next_req` twice.
- Isochronous descriptors fed with byte strobes and with alternating packet errors. A design with the wrong length unit finishes too early, and a design with a stale packet-valid flag reports the wrong error state.

// File: rtl/ep_dd_pkg.sv
package ep_dd_pkg;
  typedef enum logic [2:0] {
    ST_UNTOUCHED = 3'd0,
    ST_ACTIVE    = 3'd1,
    ST_DONE      = 3'd2,
    ST_SHORT     = 3'd3,
    ST_OVERFLOW  = 3'd4,
    ST_BUSFAULT  = 3'd5
  } dd_state_e;
endpackage

// File: rtl/ep_dd_count.sv
// Transfer counter with the latched length and an "about to reach length" flag.
module ep_dd_count #(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] len_i,
  input  logic             inc,
  output logic [LEN_W-1:0] cnt_o,
  output logic             at_last
);
  localparam int EXT_W = LEN_W + 1;

  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [EXT_W-1:0] cnt_plus;

  assign cnt_plus = {1'b0, cnt_q} + EXT_W'(1);
  assign at_last  = (cnt_plus == {1'b0, len_q});

  always_comb begin
    cnt_d = cnt_q;
    len_d = len_q;
    if (load) begin
      cnt_d = '0;
      len_d = len_i;
    end else if (inc) begin
      cnt_d = cnt_plus[LEN_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      len_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      len_q <= len_d;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ep_dd_addr.sv
// Buffer address register, stepped by the byte size of each finished packet.
module ep_dd_addr #(
  parameter int ADDR_W = 32,
  parameter int PKT_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              adv,
  input  logic [PKT_W-1:0]  step,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q, addr_d;

  always_comb begin
    addr_d = addr_q;
    if (load)     addr_d = addr_i;
    else if (adv) addr_d = addr_q + ADDR_W'(step);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/ep_dd_ctrl.sv
// Outcome decision: status code, retire, DMA enable, packet-valid, next request.
module ep_dd_ctrl
  import ep_dd_pkg::*;
#(
  parameter int PKT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_valid,
  input  logic             ld_iso,
  input  logic [PKT_W-1:0] mps,
  input  logic             byte_ev,
  input  logic             pkt_end,
  input  logic [PKT_W-1:0] pkt_bytes,
  input  logic             pkt_err,
  input  logic             bus_err,
  input  logic             at_last,
  output logic             inc,
  output logic             adv,
  output logic [2:0]       status,
  output logic             retired,
  output logic             dma_en,
  output logic             pkt_valid,
  output logic             next_req
);
  dd_state_e st_q, st_d;
  logic ret_q, ret_d, en_q, en_d, iso_q, iso_d, pv_q, pv_d, nxt_q, nxt_d;
  logic active, take, hit;

  assign active = en_q && !ret_q;
  assign take   = active && !bus_err;
  assign inc    = take && (iso_q ? pkt_end : byte_ev);
  assign adv    = take && pkt_end;
  assign hit    = !iso_q && byte_ev && at_last;

  always_comb begin
    st_d  = st_q;
    ret_d = ret_q;
    en_d  = en_q;
    iso_d = iso_q;
    pv_d  = pv_q;
    nxt_d = 1'b0;
    if (ld_valid) begin
      st_d  = ST_UNTOUCHED;
      ret_d = 1'b0;
      en_d  = 1'b1;
      iso_d = ld_iso;
      pv_d  = 1'b0;
    end else if (active && bus_err) begin
      st_d = ST_BUSFAULT;
      en_d = 1'b0;
    end else if (active) begin
      if (iso_q) begin
        if (pkt_end) begin
          pv_d = !pkt_err;
          if (at_last) begin
            st_d  = ST_DONE;
            ret_d = 1'b1;
            nxt_d = 1'b1;
          end else begin
            st_d = ST_ACTIVE;
          end
        end
      end else if (hit && pkt_end) begin
        st_d  = ST_DONE;
        ret_d = 1'b1;
        nxt_d = 1'b1;
      end else if (hit) begin
        st_d  = ST_OVERFLOW;
        ret_d = 1'b1;
        en_d  = 1'b0;
      end else if (pkt_end && (pkt_bytes < mps)) begin
        st_d  = ST_SHORT;
        ret_d = 1'b1;
        nxt_d = 1'b1;
      end else if (pkt_end) begin
        st_d = ST_ACTIVE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_UNTOUCHED;
      ret_q <= 1'b0;
      en_q  <= 1'b0;
      iso_q <= 1'b0;
      pv_q  <= 1'b0;
      nxt_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      ret_q <= ret_d;
      en_q  <= en_d;
      iso_q <= iso_d;
      pv_q  <= pv_d;
      nxt_q <= nxt_d;
    end
  end

  assign status    = st_q;
  assign retired   = ret_q;
  assign dma_en    = en_q;
  assign pkt_valid = iso_q ? pv_q : 1'b1;
  assign next_req  = nxt_q;
endmodule

// File: rtl/ep_dd_tracker.sv
module ep_dd_tracker #(
  parameter int LEN_W  = 12,
  parameter int ADDR_W = 32,
  parameter int PKT_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [LEN_W-1:0]  ld_len,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              ld_iso,
  input  logic [PKT_W-1:0]  mps,
  input  logic              byte_ev,
  input  logic              pkt_end,
  input  logic [PKT_W-1:0]  pkt_bytes,
  input  logic              pkt_err,
  input  logic              bus_err,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [LEN_W-1:0]  xfer_cnt,
  output logic [2:0]        status,
  output logic              retired,
  output logic              pkt_valid,
  output logic              dma_en,
  output logic              next_req
);
  logic inc, adv, at_last;

  ep_dd_count #(.LEN_W(LEN_W)) u_count (
    .clk(clk), .rst_n(rst_n), .load(ld_valid), .len_i(ld_len),
    .inc(inc), .cnt_o(xfer_cnt), .at_last(at_last)
  );

  ep_dd_addr #(.ADDR_W(ADDR_W), .PKT_W(PKT_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(ld_valid), .addr_i(ld_addr),
    .adv(adv), .step(pkt_bytes), .addr_o(cur_addr)
  );

  ep_dd_ctrl #(.PKT_W(PKT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_iso(ld_iso),
    .mps(mps), .byte_ev(byte_ev), .pkt_end(pkt_end), .pkt_bytes(pkt_bytes),
    .pkt_err(pkt_err), .bus_err(bus_err), .at_last(at_last),
    .inc(inc), .adv(adv), .status(status), .retired(retired),
    .dma_en(dma_en), .pkt_valid(pkt_valid), .next_req(next_req)
  );
endmodule

// File: rtl/ep_dd_tracker_sva.sv
module ep_dd_tracker_sva #(
  parameter int LEN_W  = 12,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_valid,
  input logic              bus_err,
  input logic [ADDR_W-1:0] cur_addr,
  input logic [LEN_W-1:0]  xfer_cnt,
  input logic [2:0]        status,
  input logic              retired,
  input logic              dma_en,
  input logic              next_req
);
  // R1: a load always yields a fresh, enabled, untouched descriptor
  a_r1_load_fresh: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> (status == 3'd0) && !retired && dma_en && (xfer_cnt == '0) && !next_req);

  // R5: the next-descriptor request is a single-cycle pulse on a retired descriptor
  a_r5_next_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    next_req |-> retired && ($past(retired) == 1'b0));

  // R7: overflow drops the DMA enable and retires
  a_r7_overflow_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 3'd4) |-> (!dma_en && retired && !next_req));

  // R8: bus fault drops the DMA enable without retiring
  a_r8_busfault_unretired: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 3'd5) |-> (!dma_en && !retired && !next_req));

  // R10: a finished descriptor holds still until reloaded
  a_r10_retired_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (retired && !ld_valid) |=> ($stable(cur_addr) && $stable(xfer_cnt) && $stable(status)));

  // R10: a disabled descriptor ignores bus errors
  a_r10_idle_ignores_err: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_en && bus_err && !ld_valid) |=> $stable(status));
endmodule

bind ep_dd_tracker ep_dd_tracker_sva #(.LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .bus_err(bus_err),
  .cur_addr(cur_addr), .xfer_cnt(xfer_cnt), .status(status),
  .retired(retired), .dma_en(dma_en), .next_req(next_req)
);

// File: tb/ep_dd_tracker_bench.sv
module ep_dd_tracker_bench;
  localparam int LEN_W  = 12;
  localparam int ADDR_W = 32;
  localparam int PKT_W  = 11;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ld_valid = 1'b0;
  logic [LEN_W-1:0]  ld_len = '0;
  logic [ADDR_W-1:0] ld_addr = '0;
  logic              ld_iso = 1'b0;
  logic [PKT_W-1:0]  mps = 11'd4;
  logic              byte_ev = 1'b0;
  logic              pkt_end = 1'b0;
  logic [PKT_W-1:0]  pkt_bytes = '0;
  logic              pkt_err = 1'b0;
  logic              bus_err = 1'b0;
  logic [ADDR_W-1:0] cur_addr;
  logic [LEN_W-1:0]  xfer_cnt;
  logic [2:0]        status;
  logic              retired, pkt_valid, dma_en, next_req;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // reference model state
  logic [2:0]        m_st;
  logic              m_ret, m_en, m_iso, m_pv, m_nxt;
  logic [LEN_W-1:0]  m_cnt, m_len;
  logic [ADDR_W-1:0] m_addr;

  always #5 clk = ~clk;

  ep_dd_tracker #(.LEN_W(LEN_W), .ADDR_W(ADDR_W), .PKT_W(PKT_W)) u_ep_dd_tracker (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_len(ld_len), .ld_addr(ld_addr),
    .ld_iso(ld_iso), .mps(mps), .byte_ev(byte_ev), .pkt_end(pkt_end),
    .pkt_bytes(pkt_bytes), .pkt_err(pkt_err), .bus_err(bus_err),
    .cur_addr(cur_addr), .xfer_cnt(xfer_cnt), .status(status), .retired(retired),
    .pkt_valid(pkt_valid), .dma_en(dma_en), .next_req(next_req)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_pv();
    return m_iso ? m_pv : 1'b1;
  endfunction

  task automatic model_reset();
    m_st = 3'd0; m_ret = 1'b0; m_en = 1'b0; m_iso = 1'b0; m_pv = 1'b0; m_nxt = 1'b0;
    m_cnt = '0; m_len = '0; m_addr = '0;
  endtask

  // next-state of the model from the inputs applied in this cycle
  task automatic model_step();
    logic act, hit;
    act = m_en && !m_ret;
    m_nxt = 1'b0;
    if (ld_valid) begin
      m_st = 3'd0; m_ret = 1'b0; m_en = 1'b1; m_iso = ld_iso; m_pv = 1'b0;
      m_cnt = '0; m_len = ld_len; m_addr = ld_addr;
    end else if (act && bus_err) begin
      m_st = 3'd5; m_en = 1'b0;
    end else if (act) begin
      if (m_iso) begin
        if (pkt_end) begin
          m_cnt = m_cnt + 1'b1;
          m_addr = m_addr + ADDR_W'(pkt_bytes);
          m_pv = !pkt_err;
          if (m_cnt == m_len) begin m_st = 3'd2; m_ret = 1'b1; m_nxt = 1'b1; end
          else m_st = 3'd1;
        end
      end else begin
        if (byte_ev) m_cnt = m_cnt + 1'b1;
        hit = byte_ev && (m_cnt == m_len);
        if (pkt_end) m_addr = m_addr + ADDR_W'(pkt_bytes);
        if (hit && pkt_end) begin m_st = 3'd2; m_ret = 1'b1; m_nxt = 1'b1; end
        else if (hit) begin m_st = 3'd4; m_ret = 1'b1; m_en = 1'b0; end
        else if (pkt_end && pkt_bytes < mps) begin m_st = 3'd3; m_ret = 1'b1; m_nxt = 1'b1; end
        else if (pkt_end) m_st = 3'd1;
      end
    end
  endtask

  task automatic compare_all();
    chk("R3 cur_addr", cur_addr, m_addr);
    chk("R2 xfer_cnt", xfer_cnt, m_cnt);
    chk("R4 status", status, m_st);
    chk("R5 retired", retired, m_ret);
    chk("R8 dma_en", dma_en, m_en);
    chk("R9 pkt_valid", pkt_valid, exp_pv());
    chk("R5 next_req", next_req, m_nxt);
  endtask

  // one clock: drive at negedge, update model, check after the edge
  task automatic cyc(input logic ld, input logic [LEN_W-1:0] len, input logic [ADDR_W-1:0] addr,
                     input logic iso, input logic be, input logic pe, input logic [PKT_W-1:0] pb,
                     input logic perr, input logic berr);
    @(negedge clk);
    ld_valid = ld; ld_len = len; ld_addr = addr; ld_iso = iso;
    byte_ev = be; pkt_end = pe; pkt_bytes = pb; pkt_err = perr; bus_err = berr;
    model_step();
    @(posedge clk);
    #1;
    compare_all();
  endtask

  task automatic load(input logic [LEN_W-1:0] len, input logic [ADDR_W-1:0] addr, input logic iso);
    cyc(1'b1, len, addr, iso, 1'b0, 1'b0, '0, 1'b0, 1'b0);
  endtask

  task automatic bytes(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, '0, '0, 1'b0, 1'b1, 1'b0, '0, 1'b0, 1'b0);
  endtask

  // a packet of n>=1 bytes: n-1 plain byte strobes, then the last with pkt_end
  task automatic packet(input int n);
    bytes(n - 1);
    cyc(1'b0, '0, '0, 1'b0, 1'b1, 1'b1, PKT_W'(n), 1'b0, 1'b0);
  endtask

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 reset status", status, 0);
    chk("R1 reset dma_en", dma_en, 0);
    chk("R1 reset retired", retired, 0);
    chk("R1 reset pkt_valid", pkt_valid, 1);
    @(negedge clk);
    rst_n = 1'b1;

    // R10: nothing loaded, events ignored
    cyc(1'b0, '0, '0, 1'b0, 1'b1, 1'b1, 11'd4, 1'b0, 1'b0);
    chk("R10 unloaded addr", cur_addr, 0);

    // R5: clean finish at packet boundary, two full packets of 4 into length 8
    load(12'd8, 32'h1000, 1'b0);
    chk("R1 load addr", cur_addr, 32'h1000);
    bytes(2);
    chk("R4 bytes alone keep untouched", status, 0);
    cyc(1'b0, '0, '0, 1'b0, 1'b1, 1'b0, '0, 1'b0, 1'b0);
    cyc(1'b0, '0, '0, 1'b0, 1'b1, 1'b1, 11'd4, 1'b0, 1'b0);
    chk("R4 in progress", status, 1);
    packet(4);
    chk("R5 done status", status, 2);
    chk("R5 next pulse", next_req, 1);
    chk("R3 addr after two packets", cur_addr, 32'h1008);
    cyc(1'b0, '0, '0, 1'b0, 1'b1, 1'b1, 11'd4, 1'b0, 1'b0);
    chk("R5 next drops", next_req, 0);
    chk("R10 retired addr frozen", cur_addr, 32'h1008);

    // R6: short packet ends early
    load(12'd8, 32'h2000, 1'b0);
    packet(4);
    packet(2);
    chk("R6 short status", status, 3);
    chk("R6 short retired", retired, 1);
    chk("R3 short addr", cur_addr, 32'h2006);

    // R6: zero-length packet is short
    load(12'd8, 32'h2100, 1'b0);
    cyc(1'b0, '0, '0, 1'b0, 1'b0, 1'b1, 11'd0, 1'b0, 1'b0);
    chk("R6 zero-length short", status, 3);

    // R7: buffer fills mid-packet
    load(12'd6, 32'h3000, 1'b0);
    packet(4);
    bytes(2);
    chk("R7 overflow status", status, 4);
    chk("R7 count equals length", xfer_cnt, 6);
    chk("R7 enable dropped", dma_en, 0);
    chk("R7 no next", next_req, 0);

    // R8: bus error wins over a packet end in the same cycle
    load(12'd16, 32'h4000, 1'b0);
    packet(4);
    cyc(1'b0, '0, '0, 1'b0, 1'b1, 1'b1, 11'd4, 1'b0, 1'b1);
    chk("R8 bus fault status", status, 5);
    chk("R8 not retired", retired, 0);
    chk("R8 addr untouched", cur_addr, 32'h4004);
    packet(4);
    chk("R10 fault ignores packets", xfer_cnt, 4);

    // R9 / R2: isochronous counts packets, byte strobes ignored
    load(12'd3, 32'h5000, 1'b1);
    chk("R9 iso valid clear after load", pkt_valid, 0);
    bytes(5);
    chk("R2 iso ignores bytes", xfer_cnt, 0);
    cyc(1'b0, '0, '0, 1'b0, 1'b0, 1'b1, 11'd100, 1'b1, 1'b0);
    chk("R9 iso error packet", pkt_valid, 0);
    cyc(1'b0, '0, '0, 1'b0, 1'b0, 1'b1, 11'd2, 1'b0, 1'b0);
    chk("R9 iso good packet", pkt_valid, 1);
    chk("R2 iso count", xfer_cnt, 2);
    cyc(1'b0, '0, '0, 1'b0, 1'b0, 1'b1, 11'd1, 1'b0, 1'b0);
    chk("R5 iso done", status, 2);
    chk("R3 iso addr", cur_addr, 32'h5000 + 103);

    // constrained random
    begin
      int unsigned seed;
      seed = $urandom(32'h5eed_0042);
      for (int i = 0; i < 4000; i++) begin
        logic ld, be, pe, er, pr, iso;
        logic [PKT_W-1:0] pb;
        ld  = ($urandom % 40) == 0;
        iso = ($urandom % 3) == 0;
        be  = ($urandom % 4) != 0;
        pe  = ($urandom % 4) == 0;
        pb  = PKT_W'($urandom % 6);
        pr  = ($urandom % 3) == 0;
        er  = ($urandom % 60) == 0;
        cyc(ld, LEN_W'(1 + $urandom % 8), $urandom, iso, be, pe, pb, pr, er);
      end
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule